// File: doc/BRIEF.md
# Five-Switch Unipolar PWM Gate Generator

This block drives the five power switches of a single-phase inverter that has a switched-capacitor virtual negative bus. It takes a signed modulation sample. It compares the magnitude of that sample with a triangular carrier that it builds itself from an up/down counter. It then decodes one of seven named states into the five gate signals. The sign of the reference selects the half-cycle and is latched only at a carrier valley.

In the positive half, switches 1 and 3 stay on, and switches 4 and 5 chop as a complementary pair. In the negative half, switch 5 stays on, and switches 1 and 3 chop together against switch 2. While switches 1 and 3 are on in the negative half, the zero-output state also recharges the virtual-bus capacitor.

Dead time is inserted on every complementary transition. Dead time also blanks all gates after reset and on every change of half-cycle. With a 125 MHz clock, a `car_peak` of 3125 gives a 20 kHz carrier.

The states are:
- BLANK: all gates off.
- POS: positive output.
- ZPOS: zero output in the positive half.
- DEADP: positive-half gap.
- NEG: negative output.
- ZNEG: zero output in the negative half.
- DEADN: negative-half gap.

The transitions are:
- An active state moves to its half's gap state on a comparison flip.
- A gap state moves to POS/ZPOS or NEG/ZNEG when its timer ends.
- Any state except BLANK moves to BLANK on a polarity mismatch.
- BLANK moves to the active state of the latched half when its timer ends.

Top module: `spwm5_gate`

## Requirements
- R1: The carrier count steps by one each clock, from 0 up to `car_peak` and back down to 0, so one carrier period is 2·`car_peak` clocks. A `car_peak` of 0 holds the count at 0.
- R2: Gate bit i drives switch i+1. In the positive half, `gate_o` is 01101 with `state_o`=01 (POS) while |ref| > carrier. Otherwise it is 10101 with `state_o`=00 (ZPOS). The gap state DEADP is 00101.
- R3: In the negative half, `gate_o` is 10010 with `state_o`=10 (NEG) while |ref| > carrier. Otherwise it is 10101 with `state_o`=00 (ZNEG). The gap state DEADN is 10000.
- R4: In steady state with 1 ≤ |ref| < `car_peak` and effective dead time Deff, each carrier period holds 2|ref|−1−Deff active-output clocks. It holds 2·`car_peak`−2|ref|+1−Deff zero-output clocks.
- R5: Every complementary transition passes through a gap of Deff = max(`dead_cyc`,1) clocks with `state_o`=11. During the gap both sides of the pair are off, so each period has 2·Deff gap clocks.
- R6: `neg_half_o` is loaded with the reference sign only on the clock edge at which the carrier is 0. Counting from the first edge after reset, these are edges 1, 1+2P, 1+4P, and so on.
- R7: A reference of 0 is positive polarity and stays in ZPOS (10101) for the whole period.
- R8: One edge after `neg_half_o` changes, all gates go off (BLANK, `state_o`=11). They stay off for exactly Deff clocks, then the new half's mapping applies.
- R9: While `rst` is high, `gate_o`=00000, `state_o`=11 and `neg_half_o`=0. After release, the gates stay off until the Deff-th rising edge.
- R10: `gate_o` only ever takes the values 00000, 00101, 01101, 10101, 10010 and 10000.
- R11: A magnitude above `car_peak`, including the most negative code, holds the active-output state for the whole period with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | REF_W | Signed modulation sample, in carrier counts |
| car_peak | input | CNT_W | Carrier peak count (half the period) |
| dead_cyc | input | DEAD_W | Dead time in clocks (0 acts as 1) |
| gate_o | output | 5 | Gate drives, bit i = switch i+1 |
| neg_half_o | output | 1 | Latched polarity, 1 = negative half |
| state_o | output | 2 | 00 zero, 01 positive, 10 negative, 11 gap/blank |

## Verification
The bench uses the default widths (REF_W=12, CNT_W=12, DEAD_W=4) and holds `car_peak` at 20, so one carrier period is only 40 clocks. Many steady-state periods, half-cycle changes and valley alignments therefore fit in a short run. Dead times of 0, 2, 3 and 5 cover the minimum-gap rule and several gap lengths. References of 0, ±small, +100 and −2048 cover the zero case and saturation, including the most negative code.

// File: rtl/spwm5_pkg.sv
`timescale 1ns/1ps
package spwm5_pkg;
    localparam int NUM_SW = 5;
    localparam int G_S1 = 0;
    localparam int G_S2 = 1;
    localparam int G_S3 = 2;
    localparam int G_S4 = 3;
    localparam int G_S5 = 4;

    localparam logic [1:0] CODE_ZERO = 2'b00;
    localparam logic [1:0] CODE_POS  = 2'b01;
    localparam logic [1:0] CODE_NEG  = 2'b10;
    localparam logic [1:0] CODE_GAP  = 2'b11;

    typedef enum logic [2:0] {
        ST_BLANK,
        ST_POS,
        ST_ZPOS,
        ST_DEADP,
        ST_NEG,
        ST_ZNEG,
        ST_DEADN
    } st_e;
endpackage

// File: rtl/spwm5_carrier.sv
`timescale 1ns/1ps
module spwm5_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] cnt,
    output logic             valley
);
    logic up_q;

    // Triangular carrier: 0 .. peak .. 0, period 2*peak (R1)
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (peak == '0) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (up_q) begin
            if (cnt >= peak) begin
                up_q <= 1'b0;
                cnt  <= cnt - 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                up_q <= 1'b1;
                cnt  <= cnt + 1'b1;
            end else begin
                cnt  <= cnt - 1'b1;
            end
        end
    end

    always_comb valley = (cnt == '0);
endmodule

// File: rtl/spwm5_mag.sv
`timescale 1ns/1ps
module spwm5_mag #(
    parameter int REF_W = 12
) (
    input  logic signed [REF_W-1:0] ref_in,
    output logic        [REF_W-1:0] mag,
    output logic                    neg
);
    // Magnitude of the two's complement sample; the most negative code maps to 2^(REF_W-1)
    always_comb begin
        neg = ref_in[REF_W-1];
        mag = neg ? (~unsigned'(ref_in) + 1'b1) : unsigned'(ref_in);
    end
endmodule

// File: rtl/spwm5_fsm.sv
`timescale 1ns/1ps
module spwm5_fsm
    import spwm5_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEAD_W-1:0] dead_cyc,
    input  logic              neg_pol,
    input  logic              above,
    output logic [NUM_SW-1:0] gates,
    output logic [1:0]        code
);
    st_e               st_q, st_d;
    logic [DEAD_W-1:0] tmr_q;
    logic              load;
    logic              tmr_done;

    always_comb tmr_done = (tmr_q <= DEAD_W'(1));

    // Next-state decision
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            ST_BLANK: begin
                if (tmr_done)
                    st_d = neg_pol ? (above ? ST_NEG : ST_ZNEG)
                                   : (above ? ST_POS : ST_ZPOS);
            end
            ST_POS: begin
                if (neg_pol)     begin st_d = ST_BLANK; load = 1'b1; end
                else if (!above) begin st_d = ST_DEADP; load = 1'b1; end
            end
            ST_ZPOS: begin
                if (neg_pol)     begin st_d = ST_BLANK; load = 1'b1; end
                else if (above)  begin st_d = ST_DEADP; load = 1'b1; end
            end
            ST_DEADP: begin
                if (neg_pol)       begin st_d = ST_BLANK; load = 1'b1; end
                else if (tmr_done) st_d = above ? ST_POS : ST_ZPOS;
            end
            ST_NEG: begin
                if (!neg_pol)    begin st_d = ST_BLANK; load = 1'b1; end
                else if (!above) begin st_d = ST_DEADN; load = 1'b1; end
            end
            ST_ZNEG: begin
                if (!neg_pol)    begin st_d = ST_BLANK; load = 1'b1; end
                else if (above)  begin st_d = ST_DEADN; load = 1'b1; end
            end
            ST_DEADN: begin
                if (!neg_pol)      begin st_d = ST_BLANK; load = 1'b1; end
                else if (tmr_done) st_d = above ? ST_NEG : ST_ZNEG;
            end
            default: st_d = ST_BLANK;
        endcase
    end

    // State register and gap timer
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_BLANK;
            tmr_q <= dead_cyc;
        end else begin
            st_q  <= st_d;
            if (load)
                tmr_q <= dead_cyc;
            else if (tmr_q != '0)
                tmr_q <= tmr_q - 1'b1;
        end
    end

    // Output decode
    always_comb begin
        gates = '0;
        code  = CODE_GAP;
        unique case (st_q)
            ST_BLANK: code = CODE_GAP;
            ST_POS: begin
                gates[G_S1] = 1'b1; gates[G_S3] = 1'b1; gates[G_S4] = 1'b1;
                code = CODE_POS;
            end
            ST_ZPOS, ST_ZNEG: begin
                gates[G_S1] = 1'b1; gates[G_S3] = 1'b1; gates[G_S5] = 1'b1;
                code = CODE_ZERO;
            end
            ST_DEADP: begin
                gates[G_S1] = 1'b1; gates[G_S3] = 1'b1;
                code = CODE_GAP;
            end
            ST_NEG: begin
                gates[G_S2] = 1'b1; gates[G_S5] = 1'b1;
                code = CODE_NEG;
            end
            ST_DEADN: begin
                gates[G_S5] = 1'b1;
                code = CODE_GAP;
            end
            default: code = CODE_GAP;
        endcase
    end
endmodule

// File: rtl/spwm5_gate.sv
`timescale 1ns/1ps
module spwm5_gate
    import spwm5_pkg::*;
#(
    parameter int REF_W  = 12,
    parameter int CNT_W  = 12,
    parameter int DEAD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic        [CNT_W-1:0] car_peak,
    input  logic       [DEAD_W-1:0] dead_cyc,
    output logic       [NUM_SW-1:0] gate_o,
    output logic                    neg_half_o,
    output logic              [1:0] state_o
);
    localparam int CMP_W = (REF_W > CNT_W) ? REF_W : CNT_W;

    logic [CNT_W-1:0] car_cnt;
    logic             valley;
    logic [REF_W-1:0] ref_mag;
    logic             ref_neg;
    logic             above;
    logic             pol_q;

    spwm5_carrier #(.CNT_W(CNT_W)) u_car (
        .clk    (clk),
        .rst    (rst),
        .peak   (car_peak),
        .cnt    (car_cnt),
        .valley (valley)
    );

    spwm5_mag #(.REF_W(REF_W)) u_mag (
        .ref_in (ref_in),
        .mag    (ref_mag),
        .neg    (ref_neg)
    );

    always_comb above = CMP_W'(ref_mag) > CMP_W'(car_cnt);

    // Polarity follows the reference sign only at a carrier valley (R6, R7)
    always_ff @(posedge clk) begin
        if (rst)
            pol_q <= 1'b0;
        else if (valley)
            pol_q <= ref_neg;
    end

    spwm5_fsm #(.DEAD_W(DEAD_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .dead_cyc (dead_cyc),
        .neg_pol  (pol_q),
        .above    (above),
        .gates    (gate_o),
        .code     (state_o)
    );

    always_comb neg_half_o = pol_q;
endmodule

// File: rtl/spwm5_gate_chk.sv
`timescale 1ns/1ps
module spwm5_gate_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       gate,
    input logic [1:0]       code,
    input logic             neg_half,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] peak
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && peak != '0) |-> (cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt)));
    // R1
    carrier_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= peak);
    // R10
    leg_s45_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate[3] && gate[4]));
    // R10
    leg_bridge_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate[1] && (gate[0] || gate[2])));
    // R10
    leg_pair13_chk: assert property (@(posedge clk) disable iff (rst)
        gate[0] == gate[2]);
    // R5
    gap_s5_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[4]) |-> !$past(gate[3]));
    // R5
    gap_s4_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[3]) |-> !$past(gate[4]));
    // R5
    gap_s2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate[1]) |-> !$past(gate[0]));
    // R3
    neg_map_chk: assert property (@(posedge clk) disable iff (rst)
        (code == 2'b10) |-> (gate[1] && gate[4] && !gate[0]));
    // R6
    pol_valley_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(neg_half) |-> ($past(cnt) == '0));
    // R8
    half_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(neg_half) |=> (gate == 5'b00000));
    // R9
    rst_off_chk: assert property (@(posedge clk)
        rst |=> (gate == 5'b00000 && code == 2'b11 && !neg_half));
endmodule

bind spwm5_gate spwm5_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate_o),
    .code     (state_o),
    .neg_half (neg_half_o),
    .cnt      (car_cnt),
    .peak     (car_peak)
);

// File: tb/spwm5_gate_bench.sv
`timescale 1ns/1ps
module spwm5_gate_bench;
    localparam int P  = 20;
    localparam int TP = 2 * P;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [11:0] ref_in = '0;
    logic        [11:0] car_peak = 12'(P);
    logic         [3:0] dead_cyc = 4'd3;
    logic         [4:0] gate_o;
    logic               neg_half_o;
    logic         [1:0] state_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spwm5_gate u_spwm5_gate (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .car_peak   (car_peak),
        .dead_cyc   (dead_cyc),
        .gate_o     (gate_o),
        .neg_half_o (neg_half_o),
        .state_o    (state_o)
    );

    typedef struct {
        string tag;
        bit    pol;
        int    n1, n2, n4, n5, nd, nc1, nc2;
    } exp_t;

    exp_t sb_q[$];
    bit   busy = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    function automatic bit legal(input logic [4:0] g);
        return g == 5'b00000 || g == 5'b00101 || g == 5'b01101 ||
               g == 5'b10101 || g == 5'b10010 || g == 5'b10000;
    endfunction

    // Driver: apply stimulus, let it settle, push the expected period profile
    task automatic run_case(input int r, input int d, input string tag);
        exp_t e;
        int m, deff, on, off, nd;
        @(negedge clk);
        ref_in   = 12'(r);
        dead_cyc = 4'(d);
        m    = (r < 0) ? -r : r;
        deff = (d == 0) ? 1 : d;
        if (m == 0)      begin on = 0;  off = TP; nd = 0; end
        else if (m > P)  begin on = TP; off = 0;  nd = 0; end
        else begin
            on  = 2 * m - 1 - deff;
            off = TP - (2 * m - 1) - deff;
            nd  = 2 * deff;
        end
        e.tag = tag;
        e.pol = (r < 0);
        e.nd  = nd;
        if (r < 0) begin
            e.n2 = on; e.n1 = off; e.n5 = TP; e.n4 = 0; e.nc1 = 0; e.nc2 = on;
        end else begin
            e.n4 = on; e.n5 = off; e.n1 = TP; e.n2 = 0; e.nc1 = on; e.nc2 = 0;
        end
        repeat (3 * TP) @(negedge clk);
        sb_q.push_back(e);
        wait (sb_q.size() == 0 && !busy);
    endtask

    // Monitor: measure one carrier period against the queued expectation
    initial begin
        forever begin
            exp_t e;
            int c1, c2, c4, c5, cd, k1, k2, ill, pbad;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            busy = 1'b1;
            c1 = 0; c2 = 0; c4 = 0; c5 = 0; cd = 0; k1 = 0; k2 = 0; ill = 0; pbad = 0;
            for (int i = 0; i < TP; i++) begin
                @(negedge clk);
                c1 += int'(gate_o[0]);
                c2 += int'(gate_o[1]);
                c4 += int'(gate_o[3]);
                c5 += int'(gate_o[4]);
                cd += int'(state_o == 2'b11);
                k1 += int'(state_o == 2'b01);
                k2 += int'(state_o == 2'b10);
                ill += int'(!legal(gate_o));
                pbad += int'(neg_half_o != e.pol);
            end
            check(c4 == e.n4,  e.tag, "S4 on-count",    c4, e.n4);
            check(c5 == e.n5,  e.tag, "S5 on-count",    c5, e.n5);
            check(c2 == e.n2,  e.tag, "S2 on-count",    c2, e.n2);
            check(c1 == e.n1,  e.tag, "S1 on-count",    c1, e.n1);
            check(cd == e.nd,  e.tag, "R5 gap clocks",  cd, e.nd);
            check(k1 == e.nc1, e.tag, "code 01 clocks", k1, e.nc1);
            check(k2 == e.nc2, e.tag, "code 10 clocks", k2, e.nc2);
            check(ill == 0,    "R10", "illegal gate patterns", ill, 0);
            check(pbad == 0,   e.tag, "polarity flag mismatches", pbad, 0);
            busy = 1'b0;
        end
    end

    // Posedge count since reset release, for valley alignment
    int pe = 0;
    always @(posedge clk) begin
        if (rst) pe <= 0;
        else     pe <= pe + 1;
    end

    // Polarity-change monitor: valley alignment and blank interval
    bit prev_pol = 1'b0;
    bit watch = 1'b0;
    int zrun = 0;
    always @(negedge clk) begin
        if (!rst && pe != 0) begin
            if (watch) begin
                if (gate_o == 5'b00000) zrun++;
                else begin
                    check(zrun == ((dead_cyc == 0) ? 1 : int'(dead_cyc)), "R8",
                          "blank clocks after half change", zrun,
                          (dead_cyc == 0) ? 1 : int'(dead_cyc));
                    watch = 1'b0;
                end
            end
            if (neg_half_o != prev_pol) begin
                check(pe % TP == 1, "R6", "polarity edge index mod 2P", pe % TP, 1);
                watch = 1'b1;
                zrun  = 0;
            end
            prev_pol = neg_half_o;
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        ref_in = 12'sd8;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(gate_o == 5'b00000, "R9", "gates in reset", int'(gate_o), 0);
        check(state_o == 2'b11,   "R9", "state code in reset", int'(state_o), 3);
        check(neg_half_o == 1'b0, "R9", "polarity in reset", int'(neg_half_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(gate_o == 5'b00000, "R9", "gates before dead edge", int'(gate_o), 0);
        @(negedge clk);
        // R2: first active state, carrier 2 < 8 so positive output
        check(gate_o == 5'b01101, "R2", "first gates after blank", int'(gate_o), 13);
        check(state_o == 2'b01,   "R2", "first code after blank", int'(state_o), 1);

        run_case(8,     3, "R2");
        run_case(-8,    3, "R3");
        run_case(15,    0, "R5");
        run_case(0,     3, "R7");
        run_case(-2048, 3, "R11");
        run_case(100,   3, "R11");
        run_case(-3,    2, "R4");
        run_case(12,    5, "R1");
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule